// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the first six bytes of each incoming frame, which form the 48-bit destination address, and decides whether the frame is for this station. The verdict is one accept or reject bit with a one-cycle valid strobe. The strobe appears in the cycle after the sixth address byte is taken, so the buffer writer can commit or drop the frame early.

Configuration comes from static register inputs. These are a station address split across a 32-bit low word and a 16-bit high word, a 64-bit multicast hash table split across two 32-bit words, and three mode bits: accept everything, reject broadcast, and use the hash for unicast too. While the address streams in, the block computes a CRC-32 over those six bytes. Six bits of that CRC select one bit of the hash table.

The first byte on the line is address byte 0. Preamble handling, the frame check sequence and storing the frame are handled elsewhere.

Top module: `rx_da_filter`

## Requirements
- R1: While reset is applied and after it is released, with no address bytes given, `verdict_valid` and `verdict_accept` stay 0.
- R2: `verdict_valid` is 1 for exactly one cycle: the cycle after the sixth address byte following a `frame_start` is taken. It stays 0 after the first five bytes.
- R3: Bytes that arrive after the sixth address byte produce no further verdict until the next `frame_start`.
- R4: When `cfg_promisc` is 1, every frame is accepted.
- R5: A destination of all ones (FF:FF:FF:FF:FF:FF) is rejected when `cfg_bcast_reject` is 1 and accepted when it is 0, unless R4 applies. This check takes priority over the multicast hash.
- R6: A frame is multicast when bit 0 of address byte 0 is 1. A multicast frame that is not broadcast is accepted exactly when the selected hash bit is 1. The index is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones, takes each byte LSB first, and has no final inversion. Index bit 5 picks `cfg_hash_hi` (1) or `cfg_hash_lo` (0). Index bits 4:0 pick the bit within that word.
- R7: A unicast frame is accepted when its address equals the station address. Byte 0 is `cfg_sta_hi[15:8]`, byte 1 is `cfg_sta_hi[7:0]`, byte 2 is `cfg_sta_lo[31:24]`, and so on down to byte 5 in `cfg_sta_lo[7:0]`. A difference in any single byte rejects the frame.
- R8: When `cfg_uni_hash` is 1, a unicast frame that fails the exact match is still accepted if its hash bit (as in R6) is 1. When `cfg_uni_hash` is 0, the hash has no effect on unicast frames.
- R9: A `frame_start` in the middle of an address drops the partial address. The verdict then depends only on the six bytes after the latest `frame_start`.
- R10: `verdict_accept` is 0 in every cycle where `verdict_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Strobe marking a new frame; restarts address collection |
| byte_valid | input | 1 | `byte_data` carries a frame byte this cycle |
| byte_data | input | 8 | Frame byte, destination address first |
| cfg_sta_lo | input | 32 | Station address bytes 2..5 |
| cfg_sta_hi | input | 16 | Station address bytes 0..1 |
| cfg_hash_lo | input | 32 | Hash table bits for indices 0..31 |
| cfg_hash_hi | input | 32 | Hash table bits for indices 32..63 |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_reject | input | 1 | Reject all-ones destination |
| cfg_uni_hash | input | 1 | Apply hash lookup to unicast addresses |
| verdict_valid | output | 1 | One-cycle strobe carrying the verdict |
| verdict_accept | output | 1 | 1 = accept frame, valid with `verdict_valid` |

## Verification
Every piece of internal state shows up in the next verdict, six bytes after a frame start.

- A byte counter that slips makes the strobe appear a cycle early or late. It can also make a second strobe appear on trailing bytes.
- A wrong CRC step or a wrong index slice accepts a multicast address when only a different hash bit is set.
- A stale match or broadcast flag left over from an aborted frame flips the verdict of the frame that follows.

Sweeping one hash bit per multicast address catches both kinds of fault at the first frame they touch.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

  // One byte of a reflected CRC-32, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_da_crc.sv
module rx_da_crc
  import rx_da_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic             crc_en;

  always_comb begin
    crc_base = restart ? '1 : crc_q;
    crc_next = take ? crc_step(crc_base, data) : crc_base;
    crc_en   = restart | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (crc_en) crc_q <= crc_next;
  end
endmodule

// File: rtl/rx_da_track.sv
module rx_da_track
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [NBYTES*8-1:0] station,
  output logic              take,
  output logic              last_byte,
  output logic              eq_now,
  output logic              bc_now,
  output logic              mc_now
);
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES - 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(NBYTES);

  logic [7:0]       st_byte [NBYTES];
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic             eq_q, bc_q, mc_q;
  logic             eq_base, bc_base;
  logic [7:0]       st_sel;
  logic             trk_en;

  for (genvar g = 0; g < NBYTES; g++) begin : g_sta
    assign st_byte[g] = station[(NBYTES-1-g)*8 +: 8];
  end

  always_comb begin
    cnt_base  = frame_start ? '0 : cnt_q;
    eq_base   = frame_start | eq_q;
    bc_base   = frame_start | bc_q;
    take      = byte_valid && (cnt_base < CNT_DONE);
    last_byte = take && (cnt_base == CNT_LAST);
    st_sel    = '0;
    for (int i = 0; i < NBYTES; i++)
      if (cnt_base == CNT_W'(i)) st_sel = st_byte[i];
    eq_now    = eq_base & (!take | (byte_data == st_sel));
    bc_now    = bc_base & (!take | (byte_data == 8'hFF));
    mc_now    = (take && cnt_base == '0) ? byte_data[0] : mc_q;
    cnt_d     = take ? cnt_base + 1'b1 : cnt_base;
    trk_en    = frame_start | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_DONE;
      eq_q  <= 1'b0;
      bc_q  <= 1'b0;
      mc_q  <= 1'b0;
    end else if (trk_en) begin
      cnt_q <= cnt_d;
      eq_q  <= eq_now;
      bc_q  <= bc_now;
      mc_q  <= mc_now;
    end
  end
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned HASH_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 last_byte,
  input  logic                 eq_now,
  input  logic                 bc_now,
  input  logic                 mc_now,
  input  logic [CRC_W-1:0]     crc,
  input  logic [HASH_BITS-1:0] hash_table,
  input  logic                 promisc,
  input  logic                 bcast_reject,
  input  logic                 uni_hash,
  output logic                 verdict_valid,
  output logic                 verdict_accept
);
  localparam int unsigned IDX_W = $clog2(HASH_BITS);

  logic [IDX_W-1:0] idx;
  logic             hash_hit, ok, vld_d, acc_d;

  always_comb begin
    idx      = crc[CRC_W-1 -: IDX_W];
    hash_hit = hash_table[idx];
    if (promisc)     ok = 1'b1;
    else if (bc_now) ok = !bcast_reject;
    else if (mc_now) ok = hash_hit;
    else             ok = eq_now | (uni_hash & hash_hit);
    vld_d = last_byte;
    acc_d = last_byte & ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid  <= vld_d;
      verdict_accept <= acc_d;
    end
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int unsigned HASH_BITS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic [31:0] cfg_sta_lo,
  input  logic [15:0] cfg_sta_hi,
  input  logic [31:0] cfg_hash_lo,
  input  logic [31:0] cfg_hash_hi,
  input  logic        cfg_promisc,
  input  logic        cfg_bcast_reject,
  input  logic        cfg_uni_hash,
  output logic        verdict_valid,
  output logic        verdict_accept
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             take, last_byte, eq_now, bc_now, mc_now;
  logic [CRC_W-1:0] crc_next;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rx_da_track #(.NBYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_int_n), .frame_start(frame_start),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .station({cfg_sta_hi, cfg_sta_lo}), .take(take), .last_byte(last_byte),
    .eq_now(eq_now), .bc_now(bc_now), .mc_now(mc_now)
  );

  rx_da_crc u_crc (
    .clk(clk), .rst_n(rst_int_n), .restart(frame_start), .take(take),
    .data(byte_data), .crc_next(crc_next)
  );

  rx_da_decide #(.HASH_BITS(HASH_BITS)) u_decide (
    .clk(clk), .rst_n(rst_int_n), .last_byte(last_byte), .eq_now(eq_now),
    .bc_now(bc_now), .mc_now(mc_now), .crc(crc_next),
    .hash_table({cfg_hash_hi, cfg_hash_lo}), .promisc(cfg_promisc),
    .bcast_reject(cfg_bcast_reject), .uni_hash(cfg_uni_hash),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
  );
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       cfg_promisc,
  input logic       cfg_bcast_reject,
  input logic       verdict_valid,
  input logic       verdict_accept
);
  logic [2:0] seen_q, seen_d;
  logic       ones_q, ones_d;

  always_comb begin
    seen_d = frame_start ? 3'd0 : seen_q;
    ones_d = frame_start | ones_q;
    if (byte_valid && seen_d < 3'd6) begin
      ones_d = ones_d & (byte_data == 8'hFF);
      seen_d = seen_d + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 3'd7;
      ones_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      ones_q <= ones_d;
    end
  end

  AST_QUIET_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_accept); // R10
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid); // R2
  AST_SIXTH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (seen_q == 3'd6 && $past(byte_valid))); // R3
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && $past(cfg_promisc)) |-> verdict_accept); // R4
  AST_BCAST_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && ones_q && !$past(cfg_promisc) && $past(cfg_bcast_reject))
      |-> !verdict_accept); // R5
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .byte_valid(byte_valid), .byte_data(byte_data),
  .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
  .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
);

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start, byte_valid;
  logic [7:0]  byte_data;
  logic [31:0] cfg_sta_lo, cfg_hash_lo, cfg_hash_hi;
  logic [15:0] cfg_sta_hi;
  logic        cfg_promisc, cfg_bcast_reject, cfg_uni_hash;
  logic        verdict_valid, verdict_accept;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  rx_da_filter u_dut (.*);

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ b[k]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic model(input logic [47:0] a);
    logic [63:0] tbl = {cfg_hash_hi, cfg_hash_lo};
    logic hit = tbl[hidx(a)];
    if (cfg_promisc) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !cfg_bcast_reject;
    if (a[40]) return hit;
    return (a == {cfg_sta_hi, cfg_sta_lo}) || (cfg_uni_hash && hit);
  endfunction

  function automatic logic [31:0] rnd(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Sends address a, then `extra` trailing bytes; checks strobe timing and verdict.
  task automatic send(input logic [47:0] a, input int extra, input string req);
    logic exp = model(a);
    frame_start = 1'b1; byte_valid = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      byte_valid = 1'b1; byte_data = a[47-8*i -: 8];
      @(negedge clk);
      if (i < 5) check("R2", verdict_valid, 1'b0);
    end
    check("R2", verdict_valid, 1'b1);
    check(req, verdict_accept, exp);
    byte_valid = 1'b0;
    for (int j = 0; j < extra; j++) begin
      byte_valid = 1'b1; byte_data = 8'hA5 ^ 8'(j);
      @(negedge clk);
      check("R3", verdict_valid, 1'b0);
    end
    byte_valid = 1'b0;
    @(negedge clk);
    check("R10", verdict_accept, 1'b0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] sta, a;
    rst_n = 1'b0; frame_start = 1'b0; byte_valid = 1'b0; byte_data = '0;
    cfg_sta_hi = 16'h0A1B; cfg_sta_lo = 32'h2C3D_4E5F;
    cfg_hash_lo = '0; cfg_hash_hi = '0;
    cfg_promisc = 1'b0; cfg_bcast_reject = 1'b0; cfg_uni_hash = 1'b0;
    sta = {cfg_sta_hi, cfg_sta_lo};
    repeat (3) @(negedge clk);
    check("R1", verdict_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", verdict_valid, 1'b0);
    check("R1", verdict_accept, 1'b0);

    // Exact match and single-byte mismatches.
    send(sta, 0, "R7");
    check("R7", verdict_accept, 1'b0);
    for (int i = 0; i < 6; i++) begin
      a = sta ^ (48'h01 << (8*i + 1));
      send(a, 0, "R7");
    end

    // Broadcast with both reject settings; hash all ones must not override.
    cfg_hash_lo = '1; cfg_hash_hi = '1;
    send(48'hFFFF_FFFF_FFFF, 0, "R5");
    cfg_bcast_reject = 1'b1;
    send(48'hFFFF_FFFF_FFFF, 0, "R5");
    send({8'h01, 40'h5E00_0000_01}, 0, "R6");
    cfg_hash_lo = '0; cfg_hash_hi = '0;

    // Multicast: exactly one hash bit set at the computed index, then all but it.
    for (int n = 0; n < 64; n++) begin
      lfsr = rnd(lfsr);
      a = {lfsr[15:8] | 8'h01, lfsr[31:16], lfsr[23:0]};
      {cfg_hash_hi, cfg_hash_lo} = 64'h1 << hidx(a);
      send(a, 0, "R6");
      {cfg_hash_hi, cfg_hash_lo} = ~(64'h1 << hidx(a));
      send(a, 0, "R6");
    end

    // Unicast hash mode on and off with only the hashed bit set.
    for (int n = 0; n < 16; n++) begin
      lfsr = rnd(lfsr);
      a = {lfsr[15:8] & 8'hFE, lfsr[31:16], lfsr[23:0]};
      {cfg_hash_hi, cfg_hash_lo} = 64'h1 << hidx(a);
      cfg_uni_hash = 1'b0; send(a, 0, "R8");
      cfg_uni_hash = 1'b1; send(a, 0, "R8");
    end

    // Trailing bytes after the address.
    cfg_uni_hash = 1'b0;
    send(sta, 5, "R3");

    // Aborted address followed by a full one.
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_valid = 1'b1; byte_data = 8'hFF; @(negedge clk);
    end
    byte_valid = 1'b0;
    check("R9", verdict_valid, 1'b0);
    send(sta, 0, "R9");
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      byte_valid = 1'b1; byte_data = sta[47-8*i -: 8]; @(negedge clk);
    end
    byte_valid = 1'b0;
    send(48'h0200_0000_0007, 0, "R9");

    // Mixed sweep across every mode combination.
    for (int m = 0; m < 8; m++) begin
      {cfg_promisc, cfg_bcast_reject, cfg_uni_hash} = 3'(m);
      for (int n = 0; n < 24; n++) begin
        lfsr = rnd(lfsr); cfg_hash_lo = lfsr;
        lfsr = rnd(lfsr); cfg_hash_hi = lfsr;
        lfsr = rnd(lfsr);
        case (n % 4)
          0: a = sta;
          1: a = 48'hFFFF_FFFF_FFFF;
          default: a = {lfsr[7:0], lfsr[31:8], lfsr[15:0]};
        endcase
        send(a, n % 3, m[2] ? "R4" : "R6");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule